// File: doc/BRIEF.md
# Memory Cycle Start-Delay Controller

This block sits between a bus and a static memory array. It holds back an active-low operation request for a number of 20 ns ticks before it lets a memory cycle begin. Writes always wait one fixed tick. Reads wait a number of ticks chosen by a 3-bit setting. The wait leaves room for an inhibit signal that some processors raise only after they have issued the request. If inhibit is seen anywhere in the wait, up to and including the tick on which the cycle would begin, the cycle is cancelled. No write pulse is issued and no read data is driven.

Once a read begins, the controller holds the read enable and the bus-drive enable while the request stays asserted. After the request is released, the bus-drive enable stays on for two more ticks so that data is still held on the bus. A write produces one pulse two ticks wide. A request starts at most one cycle. The controller returns to idle only after the request has been released. Address decoding and byte steering are done elsewhere. The block-select input carries their result.

Top module: `memcyc_ctrl`

## Requirements
- R1: During reset and after it, `rd_en`, `wr_pulse` and `buf_en` are 0 until a request is accepted.
- R2: A request is accepted on the rising edge (edge 0) that samples `req_n`=0 with `blk_sel`=1 while idle. `rd_wr`=1 means read. For a read, `rd_en` and `buf_en` rise after edge D, where D is the value of `rd_dly_sel` in ticks (0 to 5).
- R3: Values 6 and 7 of `rd_dly_sel` give the same delay as 5.
- R4: For a write (`rd_wr`=0), `wr_pulse` is high after edges 1 and 2 and low after edge 3, whatever the value of `rd_dly_sel`.
- R5: If `inhibit`=1 is sampled on any edge from edge 0 through the start edge (D for a read, 1 for a write), that cycle produces no `rd_en`, `wr_pulse` or `buf_en`.
- R6: `inhibit` sampled only after the start edge has no effect on a cycle already begun.
- R7: A request with `blk_sel`=0 at edge 0 is ignored, and all outputs stay 0.
- R8: `rd_en` stays high up to the edge that samples `req_n`=1. `buf_en` stays high for exactly two further ticks and then drops.
- R9: If `req_n`=1 is sampled on or before the start edge, the cycle is cancelled with no output activity.
- R10: A write pulse that has begun runs its full two ticks even if the request is released during it.
- R11: `rd_en` and `wr_pulse` are never high together. A request held low produces at most one cycle, and no new cycle starts until the request has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one period per 20 ns delay step |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 1 | Operation request, active low |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| inhibit | input | 1 | Late cancel, active high |
| blk_sel | input | 1 | Block selected by the address decode, active high |
| rd_dly_sel | input | 3 | Read start delay in ticks; 6 and 7 clamp to 5 |
| rd_en | output | 1 | Delayed read enable to the array |
| wr_pulse | output | 1 | Two-tick write pulse to the array |
| buf_en | output | 1 | Read-data bus drive enable, including hold |

## Verification
The start edge can see two events in the same tick: a late inhibit, and the release of the request. The bench provokes the first by raising inhibit exactly on the start edge for reads and for writes, and the second by releasing the request on that same edge. Both must leave every output at 0. A neighbouring case, with inhibit one tick after the start edge, must leave the cycle intact. This shows the decision boundary falls exactly on the start edge. Each tick's outputs are compared against a trace computed from the request length, delay setting and inhibit timing.

// File: rtl/memcyc_pkg.sv
`timescale 1ns/1ps
// Package: shared sequencer state encoding for the memory cycle controller.
package memcyc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // waiting for a selected request
        ST_DELAY  = 3'd1,  // counting start-delay ticks
        ST_READ   = 3'd2,  // read enable and bus drive active
        ST_HOLD   = 3'd3,  // bus drive held after request release
        ST_WPULSE = 3'd4,  // write pulse active
        ST_WAIT   = 3'd5   // cycle done or cancelled, wait for release
    } memcyc_state_t;

endpackage

// File: rtl/memcyc_dly_clamp.sv
`timescale 1ns/1ps
// Module: memcyc_dly_clamp
// Converts the raw read-delay setting into a tick count and clamps it to MAX_TICKS.
// Assumes: MAX_TICKS fits in CNT_W bits.
module memcyc_dly_clamp #(
    parameter int SEL_W     = 3,
    parameter int MAX_TICKS = 5,
    parameter int CNT_W     = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] ticks
);
    localparam int SUM_W = (SEL_W > CNT_W) ? SEL_W : CNT_W;

    logic [SUM_W-1:0] sel_ext;
    logic [SUM_W-1:0] max_ext;

    // Widen both operands so the compare is width-clean.
    always_comb begin
        sel_ext = SUM_W'(sel);
        max_ext = SUM_W'(MAX_TICKS);
    end

    // Pick the setting or the ceiling, whichever is smaller.
    always_comb begin
        if (sel_ext > max_ext) ticks = CNT_W'(MAX_TICKS);
        else                   ticks = CNT_W'(sel_ext);
    end
endmodule

// File: rtl/memcyc_tick_cnt.sv
`timescale 1ns/1ps
// Module: memcyc_tick_cnt
// Shared down-counter for delay, pulse and hold windows. A load sets the count;
// dec counts down and stops at zero. zero flags the last tick of a window.
// Assumes: load and dec are not both asserted.
module memcyc_tick_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load or count down the window register.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Flag an expired window.
    always_comb zero = (cnt_q == '0);
endmodule

// File: rtl/memcyc_seq.sv
`timescale 1ns/1ps
// Module: memcyc_seq
// Cycle sequencer: accepts a selected request, runs the start delay, applies the
// late-inhibit cancel, then steps through read/hold or write-pulse windows.
// Assumes: WR_DLY_TICKS, WR_PULSE_TICKS and HOLD_TICKS are at least 1.
module memcyc_seq
    import memcyc_pkg::*;
#(
    parameter int CNT_W          = 3,
    parameter int WR_DLY_TICKS   = 1,
    parameter int WR_PULSE_TICKS = 2,
    parameter int HOLD_TICKS     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic             rd_wr,
    input  logic             inhibit,
    input  logic             blk_sel,
    input  logic [CNT_W-1:0] rd_ticks,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_dec,
    output memcyc_state_t    state
);
    localparam logic [CNT_W-1:0] WR_DLY_LD = CNT_W'(WR_DLY_TICKS - 1);
    localparam logic [CNT_W-1:0] PULSE_LD  = CNT_W'(WR_PULSE_TICKS - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_TICKS - 1);

    memcyc_state_t state_q, state_nx;
    logic          is_rd_q, is_rd_nx;
    logic          abort_q, abort_nx;

    // Register the state, the latched direction and the sticky cancel flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            is_rd_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            is_rd_q <= is_rd_nx;
            abort_q <= abort_nx;
        end
    end

    // Next-state and counter control for each cycle phase.
    always_comb begin
        state_nx = state_q;
        is_rd_nx = is_rd_q;
        abort_nx = abort_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!req_n && blk_sel) begin
                    is_rd_nx = rd_wr;
                    abort_nx = inhibit;
                    if (rd_wr && rd_ticks == '0) begin
                        state_nx = inhibit ? ST_WAIT : ST_READ;
                    end else begin
                        state_nx = ST_DELAY;
                        cnt_load = 1'b1;
                        cnt_val  = rd_wr ? (rd_ticks - 1'b1) : WR_DLY_LD;
                    end
                end
            end
            ST_DELAY: begin
                if (req_n) begin
                    state_nx = ST_IDLE;
                end else if (cnt_zero) begin
                    if (abort_q || inhibit) begin
                        state_nx = ST_WAIT;
                    end else if (is_rd_q) begin
                        state_nx = ST_READ;
                    end else begin
                        state_nx = ST_WPULSE;
                        cnt_load = 1'b1;
                        cnt_val  = PULSE_LD;
                    end
                end else begin
                    cnt_dec  = 1'b1;
                    abort_nx = abort_q | inhibit;
                end
            end
            ST_READ: begin
                if (req_n) begin
                    state_nx = ST_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) state_nx = ST_IDLE;
                else          cnt_dec  = 1'b1;
            end
            ST_WPULSE: begin
                if (cnt_zero) state_nx = req_n ? ST_IDLE : ST_WAIT;
                else          cnt_dec  = 1'b1;
            end
            ST_WAIT: begin
                if (req_n) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Expose the current phase to the output decode.
    always_comb state = state_q;
endmodule

// File: rtl/memcyc_ctrl.sv
`timescale 1ns/1ps
// Module: memcyc_ctrl (top)
// Memory cycle start-delay controller. Delays the active-low request by a
// programmable number of ticks for reads and a fixed count for writes, cancels on
// a late inhibit, and produces read enable, write pulse and bus-drive enable.
// Assumes: one clk period equals one delay step; inputs are synchronous to clk.
module memcyc_ctrl
    import memcyc_pkg::*;
#(
    parameter int SEL_W          = 3,
    parameter int RD_MAX_TICKS   = 5,
    parameter int WR_DLY_TICKS   = 1,
    parameter int WR_PULSE_TICKS = 2,
    parameter int HOLD_TICKS     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic             rd_wr,
    input  logic             inhibit,
    input  logic             blk_sel,
    input  logic [SEL_W-1:0] rd_dly_sel,
    output logic             rd_en,
    output logic             wr_pulse,
    output logic             buf_en
);
    localparam int MAX_A     = (RD_MAX_TICKS > WR_DLY_TICKS) ? RD_MAX_TICKS : WR_DLY_TICKS;
    localparam int MAX_B     = (WR_PULSE_TICKS > HOLD_TICKS) ? WR_PULSE_TICKS : HOLD_TICKS;
    localparam int MAX_TICKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] rd_ticks;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    memcyc_state_t    state;

    memcyc_dly_clamp #(
        .SEL_W     (SEL_W),
        .MAX_TICKS (RD_MAX_TICKS),
        .CNT_W     (CNT_W)
    ) u_clamp (
        .sel   (rd_dly_sel),
        .ticks (rd_ticks)
    );

    memcyc_tick_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    memcyc_seq #(
        .CNT_W          (CNT_W),
        .WR_DLY_TICKS   (WR_DLY_TICKS),
        .WR_PULSE_TICKS (WR_PULSE_TICKS),
        .HOLD_TICKS     (HOLD_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_n    (req_n),
        .rd_wr    (rd_wr),
        .inhibit  (inhibit),
        .blk_sel  (blk_sel),
        .rd_ticks (rd_ticks),
        .cnt_zero (cnt_zero),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .cnt_dec  (cnt_dec),
        .state    (state)
    );

    // Decode the registered phase into glitch-free strobes.
    always_comb begin
        rd_en    = (state == ST_READ);
        wr_pulse = (state == ST_WPULSE);
        buf_en   = (state == ST_READ) || (state == ST_HOLD);
    end
endmodule

// File: rtl/memcyc_ctrl_chk.sv
`timescale 1ns/1ps
// Module: memcyc_ctrl_chk
// Temporal checks on the controller ports, bound to every memcyc_ctrl instance.
module memcyc_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_wr,
    input logic inhibit,
    input logic rd_en,
    input logic wr_pulse,
    input logic buf_en
);
    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_pulse));

    // R4
    wr_pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_pulse) |=> wr_pulse);

    // R4
    wr_pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && $past(wr_pulse)) |=> !wr_pulse);

    // R5
    rd_no_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> !$past(inhibit));

    // R5
    wr_no_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_pulse) |-> (!$past(inhibit) && !$past(rd_wr)));

    // R8
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> buf_en);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_en) |-> buf_en);
endmodule

bind memcyc_ctrl memcyc_ctrl_chk u_memcyc_ctrl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_wr    (rd_wr),
    .inhibit  (inhibit),
    .rd_en    (rd_en),
    .wr_pulse (wr_pulse),
    .buf_en   (buf_en)
);

// File: tb/memcyc_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes a per-tick expected trace, the monitor pops it.
module memcyc_ctrl_bench;
    localparam int CLK_PERIOD = 20;
    localparam int RD_MAX     = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic       rd_wr = 1'b1;
    logic       inhibit = 1'b0;
    logic       blk_sel = 1'b0;
    logic [2:0] rd_dly_sel = 3'd1;
    logic       rd_en, wr_pulse, buf_en;

    typedef struct {
        logic  rd;
        logic  wr;
        logic  bf;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    memcyc_ctrl u_memcyc_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n      (req_n),
        .rd_wr      (rd_wr),
        .inhibit    (inhibit),
        .blk_sel    (blk_sel),
        .rd_dly_sel (rd_dly_sel),
        .rd_en      (rd_en),
        .wr_pulse   (wr_pulse),
        .buf_en     (buf_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pop one expected tick per falling edge and compare.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if ({rd_en, wr_pulse, buf_en} !== {e.rd, e.wr, e.bf}) begin
                n_fail++;
                $display("FAIL %s: rd_en,wr_pulse,buf_en = %b%b%b expected %b%b%b",
                         e.tag, rd_en, wr_pulse, buf_en, e.rd, e.wr, e.bf);
            end
        end
    end

    task automatic drive(input bit is_rd, input int dsel, input int len,
                         input int inh_at, input int inh_len, input bit sel, input int i);
        req_n      = !(i < len);
        inhibit    = (inh_at >= 0) && (i >= inh_at) && (i < inh_at + inh_len);
        rd_wr      = is_rd;
        rd_dly_sel = dsel[2:0];
        blk_sel    = sel;
    endtask

    // Driver: one request of len ticks; inhibit high for inh_len ticks from inh_at.
    task automatic run_txn(input bit is_rd, input int dsel, input int len,
                           input int inh_at, input int inh_len, input bit sel,
                           input string tag);
        int start;
        int n;
        bit act;
        exp_t e;
        start = is_rd ? ((dsel > RD_MAX) ? RD_MAX : dsel) : 1;
        act   = sel && (start <= len - 1) && !((inh_at >= 0) && (inh_at <= start));
        n     = len + 4;
        @(posedge clk); #1;
        drive(is_rd, dsel, len, inh_at, inh_len, sel, 0);
        @(posedge clk); #1;
        for (int j = 0; j < n; j++) begin
            e.rd  = act && is_rd && (j >= start) && (j <= len - 1);
            e.bf  = act && is_rd && (j >= start) && (j <= len + 1);
            e.wr  = act && !is_rd && ((j == start) || (j == start + 1));
            e.tag = tag;
            exp_q.push_back(e);
        end
        for (int i = 1; i < n; i++) begin
            drive(is_rd, dsel, len, inh_at, inh_len, sel, i);
            @(posedge clk); #1;
        end
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic idle_chk(input string tag);
        n_chk++;
        if ({rd_en, wr_pulse, buf_en} !== 3'b000) begin
            n_fail++;
            $display("FAIL %s: rd_en,wr_pulse,buf_en = %b%b%b expected 000",
                     tag, rd_en, wr_pulse, buf_en);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_chk("R1 in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R1 after reset");
        // R2 read delays 0..5
        run_txn(1'b1, 0, 4, -1, 0, 1'b1, "R2 read d0");
        run_txn(1'b1, 1, 5, -1, 0, 1'b1, "R2 read d1");
        run_txn(1'b1, 3, 6, -1, 0, 1'b1, "R2 read d3");
        run_txn(1'b1, 5, 8, -1, 0, 1'b1, "R2 read d5");
        // R3 clamp
        run_txn(1'b1, 6, 8, -1, 0, 1'b1, "R3 read set6");
        run_txn(1'b1, 7, 9, -1, 0, 1'b1, "R3 read set7");
        // R4 write fixed delay and width
        run_txn(1'b0, 4, 5, -1, 0, 1'b1, "R4 write set4");
        // R10 release during pulse
        run_txn(1'b0, 0, 2, -1, 0, 1'b1, "R10 write short req");
        // R5 inhibit at start edge and earlier
        run_txn(1'b1, 2, 6, 2, 1, 1'b1, "R5 read inhibit on start edge");
        run_txn(1'b1, 3, 7, 1, 1, 1'b1, "R5 read inhibit early pulse");
        run_txn(1'b1, 0, 4, 0, 1, 1'b1, "R5 read d0 inhibit");
        run_txn(1'b0, 1, 5, 1, 1, 1'b1, "R5 write inhibit on start edge");
        // R6 inhibit after start
        run_txn(1'b1, 1, 5, 2, 2, 1'b1, "R6 read late inhibit");
        run_txn(1'b0, 2, 5, 2, 1, 1'b1, "R6 write late inhibit");
        // R7 not selected
        run_txn(1'b1, 1, 5, -1, 0, 1'b0, "R7 read unselected");
        run_txn(1'b0, 1, 5, -1, 0, 1'b0, "R7 write unselected");
        // R9 release on or before start edge
        run_txn(1'b1, 4, 4, -1, 0, 1'b1, "R9 read released at start");
        run_txn(1'b0, 3, 1, -1, 0, 1'b1, "R9 write released at start");
        // R11 single cycle per held request
        run_txn(1'b0, 1, 10, -1, 0, 1'b1, "R11 write held long");
        run_txn(1'b1, 2, 10, 0, 1, 1'b1, "R11 aborted read held long");
        // R8 long read hold
        run_txn(1'b1, 2, 12, -1, 0, 1'b1, "R8 read long");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule